// File: doc/BRIEF.md
# Three-Term Floating-Point Adder with One Rounding

This block adds three floating-point operands in a single operation and rounds the result only once. Each operand gets a sign pattern chosen by the operation code. The operands are `z` (the accumulator-like term), `x` and `y`. A magnitude mode instead adds the absolute values of `x` and `y`. The result equals the exact three-term sum rounded once to the working format. Two chained rounded additions can give a different answer, and this block avoids that.

The format has parameters: one sign bit, `EW` exponent bits and `FW` fraction bits, with the bias set to `2^(EW-1)-1`. The default is a 16-bit word. Every operand is placed without loss into a signed fixed-point accumulator that covers the whole normal exponent range. The exact sum then carries every bit needed to round at any precision up to the accumulator width. Rounding is round-to-nearest, ties-to-even. Subnormal inputs are treated as zeros, and results below the smallest normal are returned as zero.

A one-cycle `start` pulse launches an operation. `done` rises for one cycle exactly three clock edges later, and the rounded value is then on `result`. Operations can be issued on every cycle.

Top module: `fadd3`

## Requirements
- R1: With operation code 0..5 the result is z+x+y (0), z+x-y (1), z-x-y (2), -z+x+y (3), -z+x-y (4), -z-x-y (5).
- R2: Operation codes 6 and 7 return |x|+|y|. In these modes `z` has no effect on the result, even when `z` is NaN or infinite, and a finite or zero result always has sign 0.
- R3: A finite result is the exact three-term sum rounded once to nearest, with ties to even. It is not the result of two successive rounded additions.
- R4: After reset `done` and `result` are 0. A `start` sampled at a rising edge makes `done` high for exactly one cycle after the third rising edge, with `result` valid. `result` holds its value until the next `done`.
- R5: A NaN operand that takes part in the sum, or infinities of both signs among the signed terms, gives the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other bits 0 (0x7E00 by default).
- R6: Infinities of one sign only give an infinity of that sign. A finite sum whose rounded exponent reaches all ones gives an infinity with the sign of the sum.
- R7: An operand with a zero exponent field counts as a zero of its own sign. A nonzero sum whose rounded biased exponent is below 1 becomes a zero with the sign of the sum, so `result` never has a zero exponent with a nonzero fraction.
- R8: An exact zero sum gives +0, except when every term taking part is a zero with negative effective sign; then it gives -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation on the operands present at the same edge |
| op | input | 3 | Operation code (see R1, R2) |
| z | input | 1+EW+FW | Term whose sign the codes 3..5 invert; ignored in magnitude mode |
| x | input | 1+EW+FW | First addend |
| y | input | 1+EW+FW | Second addend |
| done | output | 1 | One-cycle strobe marking a valid result |
| result | output | 1+EW+FW | Rounded sum, held between strobes |

## Verification
The bench builds the block with its defaults, EW=5 and FW=10. Every expected word can then be worked out by hand in a 16-bit format. At these widths the spacing between representable values near 2048 is 2, so small integer operands are enough to create exact ties, to push a tie just past halfway with a tiny third term, and to cancel a large value completely. The full exponent span of 30 is also within reach of directed values, so the bench drives overflow to infinity, flushing of subnormal inputs and underflow of results directly.

// File: rtl/fadd3_pkg.sv
package fadd3_pkg;

  typedef enum logic [2:0] {
    OP_PPP  = 3'd0,
    OP_PPM  = 3'd1,
    OP_PMM  = 3'd2,
    OP_MPP  = 3'd3,
    OP_MPM  = 3'd4,
    OP_MMM  = 3'd5,
    OP_ABS  = 3'd6,
    OP_ABS2 = 3'd7
  } fadd3_op_e;

  // classification of one signed term after decode
  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_zero;
    logic neg;
  } term_cls_t;

  // bit 0 flips z, bit 1 flips x, bit 2 flips y
  function automatic logic [2:0] flip_mask(input logic [2:0] code);
    logic [2:0] m;
    case (fadd3_op_e'(code))
      OP_PPP:  m = 3'b000;
      OP_PPM:  m = 3'b100;
      OP_PMM:  m = 3'b110;
      OP_MPP:  m = 3'b001;
      OP_MPM:  m = 3'b101;
      OP_MMM:  m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

  function automatic logic abs_mode(input logic [2:0] code);
    return (fadd3_op_e'(code) == OP_ABS) || (fadd3_op_e'(code) == OP_ABS2);
  endfunction

endpackage

// File: rtl/fadd3_term.sv
module fadd3_term
  import fadd3_pkg::*;
#(
  parameter int EW = 5,
  parameter int FW = 10,
  localparam int W = 1 + EW + FW,
  localparam int MAGW = FW + (1 << EW) - 2
) (
  input  logic              [W-1:0] opnd,
  input  logic                      negate,
  input  logic                      absolute,
  input  logic                      active,
  output term_cls_t                 cls,
  output logic signed [MAGW:0]      aligned
);

  localparam logic [EW-1:0] EXP_ONES = '1;

  // place the significand so that its LSB weight is that of exponent 1
  function automatic logic [MAGW-1:0] place(input logic [EW-1:0] e,
                                            input logic [FW-1:0] f);
    logic [MAGW-1:0] v;
    v = MAGW'({1'b1, f});
    return v << (e - 1'b1);
  endfunction

  logic [EW-1:0]   ex;
  logic [FW-1:0]   fr;
  logic            normal;
  logic [MAGW-1:0] mag;

  always_comb begin
    ex     = opnd[W-2:FW];
    fr     = opnd[FW-1:0];
    normal = active && (ex != '0) && (ex != EXP_ONES);
    mag    = normal ? place(ex, fr) : '0;

    cls.is_nan  = active && (ex == EXP_ONES) && (fr != '0);
    cls.is_inf  = active && (ex == EXP_ONES) && (fr == '0);
    cls.is_zero = !active || (ex == '0);
    // an inactive term behaves as -0: neutral for the zero-sign rule
    cls.neg     = active ? ((opnd[W-1] & ~absolute) ^ negate) : 1'b1;

    aligned = cls.neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/fadd3_round.sv
module fadd3_round #(
  parameter int EW = 5,
  parameter int FW = 10,
  parameter int MW = 42
) (
  input  logic [MW-1:0] mag,
  output logic [EW-1:0] exp_o,
  output logic [FW-1:0] frac_o,
  output logic          ovf,
  output logic          uf
);

  function automatic int lead_pos(input logic [MW-1:0] m);
    int p;
    p = 0;
    for (int i = 0; i < MW; i++) begin
      if (m[i]) p = i;
    end
    return p;
  endfunction

  logic [MW-1:0] norm;
  logic [FW:0]   sig;
  logic          grd;
  logic          stk;
  logic          up;
  logic [FW+1:0] rsig;
  int            p;
  int            e;

  always_comb begin
    p    = lead_pos(mag);
    norm = mag << (MW - 1 - p);
    sig  = norm[MW-1 -: FW+1];
    grd  = norm[MW-2-FW];
    stk  = |norm[MW-3-FW:0];
    up   = grd & (stk | sig[0]);
    rsig = {1'b0, sig} + (FW+2)'(up);
    e    = p - FW + 1 + (rsig[FW+1] ? 1 : 0);
    ovf  = e >= ((1 << EW) - 1);
    uf   = e < 1;
    exp_o  = EW'(e);
    frac_o = rsig[FW+1] ? '0 : rsig[FW-1:0];
  end

endmodule

// File: rtl/fadd3.sv
module fadd3
  import fadd3_pkg::*;
#(
  parameter int EW = 5,
  parameter int FW = 10,
  localparam int W = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] z,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int MAGW = FW + (1 << EW) - 2;
  localparam int MW   = MAGW + 2;
  localparam int ACCW = MW + 1;
  localparam int NT   = 3;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  function automatic logic signed [ACCW-1:0] widen(input logic signed [MAGW:0] v);
    return {{(ACCW-MAGW-1){v[MAGW]}}, v};
  endfunction

  // ---------------- stage 0: decode and align ----------------
  logic [W-1:0]            opnd   [NT];
  logic [NT-1:0]           flips;
  logic [NT-1:0]           act;
  logic                    abs_c;
  term_cls_t               cls_c  [NT];
  logic signed [MAGW:0]    al_c   [NT];

  assign opnd[0] = z;
  assign opnd[1] = x;
  assign opnd[2] = y;
  assign flips   = flip_mask(op);
  assign abs_c   = abs_mode(op);
  assign act     = {1'b1, 1'b1, ~abs_c};

  for (genvar i = 0; i < NT; i++) begin : g_term
    fadd3_term #(.EW(EW), .FW(FW)) u_term (
      .opnd    (opnd[i]),
      .negate  (flips[i]),
      .absolute(abs_c),
      .active  (act[i]),
      .cls     (cls_c[i]),
      .aligned (al_c[i])
    );
  end

  logic                 s1_valid;
  logic                 s1_abs;
  term_cls_t            s1_cls [NT];
  logic signed [MAGW:0] s1_al  [NT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_abs   <= 1'b0;
      for (int i = 0; i < NT; i++) begin
        s1_cls[i] <= '0;
        s1_al[i]  <= '0;
      end
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_abs <= abs_c;
        for (int i = 0; i < NT; i++) begin
          s1_cls[i] <= cls_c[i];
          s1_al[i]  <= al_c[i];
        end
      end
    end
  end

  // ---------------- stage 1: exact sum and special cases ----------------
  logic signed [ACCW-1:0] sum_c;
  logic                   nan_c;
  logic                   pinf_c;
  logic                   ninf_c;
  logic                   allneg0_c;

  always_comb begin
    sum_c     = '0;
    nan_c     = 1'b0;
    pinf_c    = 1'b0;
    ninf_c    = 1'b0;
    allneg0_c = 1'b1;
    for (int i = 0; i < NT; i++) begin
      sum_c     = sum_c + widen(s1_al[i]);
      nan_c     = nan_c | s1_cls[i].is_nan;
      pinf_c    = pinf_c | (s1_cls[i].is_inf & ~s1_cls[i].neg);
      ninf_c    = ninf_c | (s1_cls[i].is_inf & s1_cls[i].neg);
      allneg0_c = allneg0_c & s1_cls[i].is_zero & s1_cls[i].neg;
    end
  end

  logic          s2_valid;
  logic [MW-1:0] s2_mag;
  logic          s2_neg;
  logic          s2_nan;
  logic          s2_inf;
  logic          s2_inf_neg;
  logic          s2_allneg0;
  logic          s2_abs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid   <= 1'b0;
      s2_mag     <= '0;
      s2_neg     <= 1'b0;
      s2_nan     <= 1'b0;
      s2_inf     <= 1'b0;
      s2_inf_neg <= 1'b0;
      s2_allneg0 <= 1'b0;
      s2_abs     <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_mag     <= sum_c[ACCW-1] ? MW'(-sum_c) : MW'(sum_c);
        s2_neg     <= sum_c[ACCW-1];
        s2_nan     <= nan_c | (pinf_c & ninf_c);
        s2_inf     <= pinf_c | ninf_c;
        s2_inf_neg <= ninf_c;
        s2_allneg0 <= allneg0_c;
        s2_abs     <= s1_abs;
      end
    end
  end

  // named events observed by the checker
  logic s2_sum_zero;
  logic s2_special;
  assign s2_sum_zero = (s2_mag == '0);
  assign s2_special  = s2_nan | s2_inf;

  // ---------------- stage 2: normalize and round ----------------
  logic [EW-1:0] r_exp;
  logic [FW-1:0] r_frac;
  logic          r_ovf;
  logic          r_uf;

  fadd3_round #(.EW(EW), .FW(FW), .MW(MW)) u_round (
    .mag   (s2_mag),
    .exp_o (r_exp),
    .frac_o(r_frac),
    .ovf   (r_ovf),
    .uf    (r_uf)
  );

  logic [W-1:0] res_c;

  always_comb begin
    if (s2_nan)           res_c = QNAN;
    else if (s2_inf)      res_c = {s2_inf_neg, {EW{1'b1}}, {FW{1'b0}}};
    else if (s2_sum_zero) res_c = {s2_allneg0, {(W-1){1'b0}}};
    else if (r_ovf)       res_c = {s2_neg, {EW{1'b1}}, {FW{1'b0}}};
    else if (r_uf)        res_c = {s2_neg, {(W-1){1'b0}}};
    else                  res_c = {s2_neg, r_exp, r_frac};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= s2_valid;
      if (s2_valid) result <= res_c;
    end
  end

endmodule

// File: rtl/fadd3_chk.sv
module fadd3_chk #(
  parameter int EW = 5,
  parameter int FW = 10,
  localparam int W = 1 + EW + FW
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [W-1:0] result,
  input logic         s2_valid,
  input logic         s2_sum_zero,
  input logic         s2_special,
  input logic         s2_abs
);

  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 done);

  // R4
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R5
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&result[W-2:FW]) && (|result[FW-1:0])) |-> (result == QNAN));

  // R7
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !((result[W-2:FW] == '0) && (result[FW-1:0] != '0)));

  // R2
  abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_abs) |=> (result[W-1] == 1'b0));

  // R8
  zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_sum_zero && !s2_special) |=> (result[W-2:0] == '0));

endmodule

bind fadd3 fadd3_chk #(.EW(EW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .result     (result),
  .s2_valid   (s2_valid),
  .s2_sum_zero(s2_sum_zero),
  .s2_special (s2_special),
  .s2_abs     (s2_abs)
);

// File: tb/fadd3_tb.sv
`timescale 1ns/1ps
module fadd3_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] z = '0;
  logic [15:0] x = '0;
  logic [15:0] y = '0;
  logic        done;
  logic [15:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fadd3 #(.EW(5), .FW(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .z(z), .x(x), .y(y), .done(done), .result(result)
  );

  localparam logic [15:0] P0 = 16'h0000, N0 = 16'h8000;
  localparam logic [15:0] ONE = 16'h3C00, NONE = 16'hBC00;
  localparam logic [15:0] TWO = 16'h4000, NTWO = 16'hC000;
  localparam logic [15:0] THREE = 16'h4200, NTHREE = 16'hC200;
  localparam logic [15:0] FOUR = 16'h4400, FIVE = 16'h4500, SIX = 16'h4600;
  localparam logic [15:0] BIG = 16'h6800, NBIG = 16'hE800;
  localparam logic [15:0] TINY = 16'h1400;
  localparam logic [15:0] PINF = 16'h7C00, NINF = 16'hFC00, QNAN = 16'h7E00;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operation, result sampled after the third rising edge
  task automatic run(input string req, input logic [2:0] code,
                     input logic [15:0] zz, input logic [15:0] xx,
                     input logic [15:0] yy, input logic [15:0] exp);
    @(negedge clk);
    start = 1'b1; op = code; z = zz; x = xx; y = yy;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req, {15'd0, done}, 16'd1);
    check(req, result, exp);
  endtask

  task automatic t_reset;
    check("R4 reset done", {15'd0, done}, 16'd0);
    check("R4 reset result", result, 16'h0000);
  endtask

  task automatic t_codes;
    run("R1 code0", 3'd0, ONE, TWO, THREE, SIX);
    run("R1 code1", 3'd1, FOUR, TWO, ONE, FIVE);
    run("R1 code2", 3'd2, ONE, TWO, THREE, 16'hC400);
    run("R1 code3", 3'd3, ONE, TWO, THREE, FOUR);
    run("R1 code4", 3'd4, ONE, TWO, THREE, NTWO);
    run("R1 code5", 3'd5, ONE, TWO, THREE, 16'hC600);
  endtask

  task automatic t_single_round;
    // 2048 + 1 + 2^-10 lies just above the tie: rounds up to 2050
    run("R3 past tie", 3'd0, BIG, ONE, TINY, 16'h6801);
    // 2048 + 1 is an exact tie: even neighbour 2048
    run("R3 tie even low", 3'd0, BIG, ONE, P0, BIG);
    // 2050 + 1 is a tie: even neighbour 2052
    run("R3 tie even high", 3'd0, 16'h6801, ONE, P0, 16'h6802);
    // 2048 + 1 - 2048 is exactly 1
    run("R3 cancel", 3'd0, BIG, ONE, NBIG, ONE);
  endtask

  task automatic t_abs;
    run("R2 abs z nan", 3'd6, QNAN, NTWO, NTHREE, FIVE);
    run("R2 abs z inf", 3'd7, NINF, NONE, TWO, THREE);
    run("R2 abs neg zeros", 3'd6, N0, N0, N0, P0);
  endtask

  task automatic t_nan_inf;
    run("R5 snan in", 3'd0, ONE, 16'h7C01, ONE, QNAN);
    run("R5 inf minus inf", 3'd0, PINF, NINF, ONE, QNAN);
    run("R5 signed inf clash", 3'd1, PINF, ONE, PINF, QNAN);
    run("R6 neg inf", 3'd2, ONE, PINF, TWO, NINF);
    run("R6 overflow", 3'd0, 16'h7BFF, 16'h7BFF, P0, PINF);
    run("R6 neg overflow", 3'd5, 16'h7BFF, 16'h7BFF, P0, NINF);
  endtask

  task automatic t_flush;
    run("R7 subnormal in", 3'd0, 16'h03FF, 16'h0400, P0, 16'h0400);
    run("R7 underflow pos", 3'd1, 16'h0401, P0, 16'h0400, P0);
    run("R7 underflow neg", 3'd4, 16'h0401, 16'h0400, P0, N0);
  endtask

  task automatic t_zero_sign;
    run("R8 all neg zero", 3'd0, N0, N0, N0, N0);
    run("R8 mixed zeros", 3'd0, P0, N0, N0, P0);
    run("R8 cancel nonzero", 3'd0, ONE, NONE, N0, P0);
    run("R8 negated zeros", 3'd5, P0, P0, P0, N0);
  endtask

  task automatic t_latency;
    logic [15:0] held;
    @(negedge clk);
    start = 1'b1; op = 3'd0; z = ONE; x = ONE; y = ONE;
    @(negedge clk);
    start = 1'b0;
    check("R4 no done at 1", {15'd0, done}, 16'd0);
    @(negedge clk);
    check("R4 no done at 2", {15'd0, done}, 16'd0);
    @(negedge clk);
    check("R4 done at 3", {15'd0, done}, 16'd1);
    check("R4 value at 3", result, THREE);
    held = result;
    x = NONE; z = TWO;
    @(negedge clk);
    check("R4 done one cycle", {15'd0, done}, 16'd0);
    @(negedge clk);
    check("R4 result held", result, held);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    start = 1'b1; op = 3'd0; z = ONE; x = TWO; y = THREE;
    @(negedge clk);
    op = 3'd1; z = FOUR; x = TWO; y = ONE;
    @(negedge clk);
    op = 3'd6; z = PINF; x = NTWO; y = NTWO;
    @(negedge clk);
    start = 1'b0;
    check("R4 pipe first", result, SIX);
    @(negedge clk);
    check("R1 pipe second", result, FIVE);
    check("R4 pipe done", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R2 pipe third", result, FOUR);
    @(negedge clk);
    check("R4 pipe drained", {15'd0, done}, 16'd0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_single_round();
    t_abs();
    t_nan_inf();
    t_flush();
    t_zero_sign();
    t_latency();
    t_pipeline();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule